// File: doc/BRIEF.md
# Serial Configuration Write Port with Video-Locked Commit

This block is a write-only slave on a three-wire configuration bus: a serial clock, a serial data line and an active-high load strobe that is held low for the length of a frame. Each frame carries an 8-bit register address and a 6-bit data value. Both fields are sent least significant bit first, and the address comes first. The block does not update its registers as bits arrive. It places each write in a staging copy and moves the staged copy into the live register bank at a defined commit point.

Each register belongs to one of two update classes. Strobe-class registers commit when the load strobe closes a complete frame. Video-class registers commit at the first horizontal-sync falling edge that follows a vertical-sync falling edge, so a register change never tears a video line. Two 12-bit registers are each assembled from a low-half address and a high-half address, and they commit only once the high half has been written. A freeze register halts every commit while it is set. All serial and sync inputs pass through two-flop synchronizers into the system clock domain before any edge is detected. A host therefore drives the bus at a fraction of the system clock rate and holds each data bit steady across the serial clock rising edge.

Top module: `tw_cfg_port`

## Requirements
- R1: After reset the outputs read reg_a_o=0x15, reg_b_o=0x2A, wide_c_o=0x3C5, wide_d_o=0x0F0 and freeze_o=0.
- R2: While sl_i is low, sdata_i is sampled on each sck_i rising edge. Bits 0..7 form the address and bits 8..13 form the data, each field least significant bit first.
- R3: Bits after the 14th in a frame (for example the two padding bits of a 16-bit host) are ignored.
- R4: A frame that holds fewer than 14 bits when sl_i rises is discarded, and no output changes.
- R5: Address 0x10 is the strobe-class register reg_a_o. It takes its new data at the sl_i rising edge that ends the frame.
- R6: Address 0x11 is the video-class register reg_b_o. It takes its staged data at the first hd_i falling edge after a vd_i falling edge. An hd_i falling edge with no vd_i falling edge before it since the last commit point leaves it unchanged.
- R7: wide_c_o is strobe-class. Address 0x20 stages bits 5:0 and address 0x21 stages bits 11:6. The output does not change after a low-half write. After the high-half write it shows {high, low}.
- R8: wide_d_o is video-class, with its low half at 0x22 and its high half at 0x23. It shows {high, low} only after the high-half write and a vd_i-then-hd_i commit.
- R9: Bit 0 written to address 0x30 sets freeze_o at the sl_i edge. While freeze_o is 1, no register commits. Staged data is kept. The frame that clears freeze_o does not commit. The next complete frame, or the next video commit point, commits the kept data.
- R10: A complete frame to any other address changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| sl_i | input | 1 | Load strobe, low during a frame |
| vd_i | input | 1 | Vertical sync, falling edge arms video commit |
| hd_i | input | 1 | Horizontal sync, falling edge performs armed commit |
| reg_a_o | output | 6 | Live strobe-class register |
| reg_b_o | output | 6 | Live video-class register |
| wide_c_o | output | 12 | Live strobe-class double-wide register |
| wide_d_o | output | 12 | Live video-class double-wide register |
| freeze_o | output | 1 | Live commit-freeze bit |

## Verification
The assertions check on every cycle that the strobe-class outputs move only just after a complete frame. They also check that the video-class outputs move only just after a synchronized horizontal falling edge, that nothing moves in a cycle following one where freeze was set, and that the frame-complete pulse lasts a single cycle. The bench scenarios are needed for the rest: the bit order, padding and short-frame rules, the wait for the high half of a double-wide register, the demand for a vertical edge before the horizontal one, and whether staged data survives a freeze and commits afterwards.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;
    localparam int AW     = 8;
    localparam int DW     = 6;
    localparam int WW     = 2 * DW;
    localparam int FRM_W  = AW + DW;
    localparam int CNT_W  = $clog2(FRM_W + 3);
    localparam int CNT_MX = FRM_W + 2;

    localparam logic [AW-1:0] ADR_A    = 8'h10;
    localparam logic [AW-1:0] ADR_B    = 8'h11;
    localparam logic [AW-1:0] ADR_C_LO = 8'h20;
    localparam logic [AW-1:0] ADR_C_HI = 8'h21;
    localparam logic [AW-1:0] ADR_D_LO = 8'h22;
    localparam logic [AW-1:0] ADR_D_HI = 8'h23;
    localparam logic [AW-1:0] ADR_FRZ  = 8'h30;

    localparam logic [DW-1:0] DEF_A = 6'h15;
    localparam logic [DW-1:0] DEF_B = 6'h2A;
    localparam logic [WW-1:0] DEF_C = 12'h3C5;
    localparam logic [WW-1:0] DEF_D = 12'h0F0;

    typedef struct packed {
        logic [DW-1:0] live;
        logic [DW-1:0] stg;
        logic          pend;
    } narrow_t;

    typedef struct packed {
        logic [WW-1:0] live;
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        logic          pend;
    } wide_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int         W   = 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST;
            stab_q <= RST;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/tw_deser.sv
module tw_deser
    import tw_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_rise,
    input  logic          sdata,
    input  logic          sl_lvl,
    input  logic          sl_rise,
    output logic          frm_v,
    output logic [AW-1:0] frm_addr,
    output logic [DW-1:0] frm_data
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [FRM_W-1:0] bits;
        logic             v;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
    } dstate_t;

    dstate_t q, d;

    always_comb begin
        d   = q;
        d.v = 1'b0;
        if (sl_rise && (q.cnt >= CNT_W'(FRM_W))) begin
            d.v    = 1'b1;
            d.addr = q.bits[AW-1:0];
            d.data = q.bits[FRM_W-1:AW];
        end
        if (sl_lvl) begin
            d.cnt = '0;
        end else if (sck_rise) begin
            if (q.cnt < CNT_W'(FRM_W))
                d.bits[q.cnt[3:0]] = sdata;
            if (q.cnt < CNT_W'(CNT_MX))
                d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign frm_v    = q.v;
    assign frm_addr = q.addr;
    assign frm_data = q.data;
endmodule

// File: rtl/tw_cfg_port.sv
module tw_cfg_port
    import tw_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_i,
    input  logic          sdata_i,
    input  logic          sl_i,
    input  logic          vd_i,
    input  logic          hd_i,
    output logic [DW-1:0] reg_a_o,
    output logic [DW-1:0] reg_b_o,
    output logic [WW-1:0] wide_c_o,
    output logic [WW-1:0] wide_d_o,
    output logic          freeze_o
);
    // synchronized levels: {sck, sdata, sl, vd, hd}
    logic [4:0] lvl;

    tw_sync #(.W(5), .RST(5'b00111)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sck_i, sdata_i, sl_i, vd_i, hd_i}),
        .sync_o  (lvl)
    );

    typedef struct packed {
        logic [3:0] prev;   // {sck, sl, vd, hd}
        narrow_t    a;
        narrow_t    b;
        wide_t      c;
        wide_t      dw;
        logic       frz;
        logic       armed;
    } state_t;

    state_t q, d;

    logic sck_rise, sl_rise, vd_fall, hd_fall;
    assign sck_rise = lvl[4] & ~q.prev[3];
    assign sl_rise  = lvl[2] & ~q.prev[2];
    assign vd_fall  = ~lvl[1] & q.prev[1];
    assign hd_fall  = ~lvl[0] & q.prev[0];

    logic          frm_v;
    logic [AW-1:0] frm_addr;
    logic [DW-1:0] frm_data;

    tw_deser u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .sdata    (lvl[3]),
        .sl_lvl   (lvl[2]),
        .sl_rise  (sl_rise),
        .frm_v    (frm_v),
        .frm_addr (frm_addr),
        .frm_data (frm_data)
    );

    always_comb begin
        d      = q;
        d.prev = {lvl[4], lvl[2], lvl[1], lvl[0]};

        // staging of a completed frame
        if (frm_v) begin
            case (frm_addr)
                ADR_A:    begin d.a.stg = frm_data; d.a.pend = 1'b1; end
                ADR_B:    begin d.b.stg = frm_data; d.b.pend = 1'b1; end
                ADR_C_LO: d.c.lo = frm_data;
                ADR_C_HI: begin d.c.hi = frm_data; d.c.pend = 1'b1; end
                ADR_D_LO: d.dw.lo = frm_data;
                ADR_D_HI: begin d.dw.hi = frm_data; d.dw.pend = 1'b1; end
                ADR_FRZ:  d.frz = frm_data[0];
                default:  ;
            endcase
        end

        // strobe-class commit point
        if (frm_v && !q.frz) begin
            if (d.a.pend) begin
                d.a.live = d.a.stg;
                d.a.pend = 1'b0;
            end
            if (d.c.pend) begin
                d.c.live = {d.c.hi, d.c.lo};
                d.c.pend = 1'b0;
            end
        end

        // video-class commit point
        if (vd_fall)
            d.armed = 1'b1;
        if (hd_fall && q.armed) begin
            d.armed = vd_fall;
            if (!q.frz) begin
                if (d.b.pend) begin
                    d.b.live = d.b.stg;
                    d.b.pend = 1'b0;
                end
                if (d.dw.pend) begin
                    d.dw.live = {d.dw.hi, d.dw.lo};
                    d.dw.pend = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.prev     <= 4'b0111;
            q.a.live   <= DEF_A;
            q.a.stg    <= DEF_A;
            q.b.live   <= DEF_B;
            q.b.stg    <= DEF_B;
            q.c.live   <= DEF_C;
            q.c.lo     <= DEF_C[DW-1:0];
            q.c.hi     <= DEF_C[WW-1:DW];
            q.dw.live  <= DEF_D;
            q.dw.lo    <= DEF_D[DW-1:0];
            q.dw.hi    <= DEF_D[WW-1:DW];
        end else begin
            q <= d;
        end
    end

    assign reg_a_o  = q.a.live;
    assign reg_b_o  = q.b.live;
    assign wide_c_o = q.c.live;
    assign wide_d_o = q.dw.live;
    assign freeze_o = q.frz;
endmodule

// File: rtl/tw_cfg_chk.sv
module tw_cfg_chk
    import tw_cfg_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          frm_v,
    input logic          hd_fall,
    input logic [DW-1:0] a,
    input logic [DW-1:0] b,
    input logic [WW-1:0] c,
    input logic [WW-1:0] dw,
    input logic          frz
);
    // R5
    a_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(a) |-> $past(frm_v));

    // R6
    b_on_hsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(b) |-> $past(hd_fall));

    // R7
    c_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(c) |-> $past(frm_v));

    // R8
    d_on_hsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dw) |-> $past(hd_fall));

    // R9
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frz) |-> ($stable(a) && $stable(b) && $stable(c) && $stable(dw)));

    // R4
    frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_v |=> !frm_v);
endmodule

bind tw_cfg_port tw_cfg_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .frm_v   (frm_v),
    .hd_fall (hd_fall),
    .a       (reg_a_o),
    .b       (reg_b_o),
    .c       (wide_c_o),
    .dw      (wide_d_o),
    .frz     (freeze_o)
);

// File: tb/tw_cfg_port_test.sv
`timescale 1ns/1ps
module tw_cfg_port_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sdata = 1'b0, sl = 1'b1, vd = 1'b1, hd = 1'b1;
    logic [5:0]  a_o, b_o;
    logic [11:0] c_o, d_o;
    logic        frz_o;

    int checks = 0;
    int errors = 0;

    logic [5:0]  exp_a, exp_b;
    logic [11:0] exp_c, exp_d;

    always #4 clk = ~clk;

    tw_cfg_port uut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdata_i(sdata), .sl_i(sl),
        .vd_i(vd), .hd_i(hd), .reg_a_o(a_o), .reg_b_o(b_o),
        .wide_c_o(c_o), .wide_d_o(d_o), .freeze_o(frz_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] frame_word(input logic [7:0] ad, input logic [5:0] dt,
                                               input logic [1:0] ex);
        return {ex, dt, ad};
    endfunction

    task automatic send(input logic [7:0] ad, input logic [5:0] dt, input int nb,
                        input logic [1:0] ex);
        logic [15:0] w;
        w  = frame_word(ad, dt, ex);
        sl = 1'b0;
        tick(4);
        for (int i = 0; i < nb; i++) begin
            sdata = w[i];
            tick(3);
            sck = 1'b1;
            tick(4);
            sck = 1'b0;
            tick(1);
        end
        tick(3);
        sl = 1'b1;
        tick(10);
    endtask

    task automatic vsync_hsync();
        vd = 1'b0; tick(6);
        vd = 1'b1; tick(6);
        hd = 1'b0; tick(6);
        hd = 1'b1; tick(6);
    endtask

    task automatic hsync_only();
        hd = 1'b0; tick(6);
        hd = 1'b1; tick(6);
    endtask

    task automatic all_out(input string tag);
        chk(tag, {6'h0, a_o}, {6'h0, exp_a});
        chk(tag, {6'h0, b_o}, {6'h0, exp_b});
        chk(tag, c_o, exp_c);
        chk(tag, d_o, exp_d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete (R1..R10 unfinished)");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [5:0] dt, dh;
        logic [1:0] ex;
        int nb;
        void'($urandom(32'd4711));
        tick(3);
        rst_n = 1'b1;
        tick(5);

        // R1 reset values
        exp_a = 6'h15; exp_b = 6'h2A; exp_c = 12'h3C5; exp_d = 12'h0F0;
        all_out("R1");
        chk("R1 freeze", {11'h0, frz_o}, 12'h0);

        // R2 / R5 directed write
        send(8'h10, 6'h2B, 14, 2'b00);
        exp_a = 6'h2B;
        chk("R2 R5 strobe write", {6'h0, a_o}, {6'h0, exp_a});

        // R3 / R2 random, with padding bits sometimes present
        for (int k = 0; k < 16; k++) begin
            dt = 6'($urandom);
            ex = 2'($urandom);
            nb = ($urandom % 2 == 0) ? 14 : 16;
            send(8'h10, dt, nb, ex);
            exp_a = dt;
            chk(nb == 16 ? "R3 padded frame" : "R2 plain frame", {6'h0, a_o}, {6'h0, exp_a});
        end

        // R4 short frames
        send(8'h10, ~exp_a, 13, 2'b00);
        chk("R4 short 13", {6'h0, a_o}, {6'h0, exp_a});
        send(8'h10, ~exp_a, 7, 2'b00);
        all_out("R4 short 7");

        // R10 unmapped
        send(8'h55, 6'h3F, 14, 2'b00);
        all_out("R10 unmapped 0x55");
        send(8'h12, 6'h01, 16, 2'b11);
        all_out("R10 unmapped 0x12");

        // R6 video-class narrow
        send(8'h11, 6'h11, 14, 2'b00);
        chk("R6 staged only", {6'h0, b_o}, {6'h0, exp_b});
        hsync_only();
        chk("R6 hd without vd", {6'h0, b_o}, {6'h0, exp_b});
        vsync_hsync();
        exp_b = 6'h11;
        chk("R6 vd then hd", {6'h0, b_o}, {6'h0, exp_b});

        // R7 wide strobe-class, directed then random
        send(8'h20, 6'h05, 14, 2'b00);
        chk("R7 low half only", c_o, exp_c);
        send(8'h21, 6'h3A, 14, 2'b00);
        exp_c = 12'hE85;
        chk("R7 high half", c_o, exp_c);
        for (int k = 0; k < 6; k++) begin
            dt = 6'($urandom);
            dh = 6'($urandom);
            send(8'h20, dt, 16, 2'($urandom));
            chk("R7 random low", c_o, exp_c);
            send(8'h21, dh, 14, 2'b00);
            exp_c = {dh, dt};
            chk("R7 random pair", c_o, exp_c);
        end

        // R8 wide video-class
        send(8'h22, 6'h2C, 14, 2'b00);
        send(8'h23, 6'h13, 14, 2'b00);
        chk("R8 staged only", d_o, exp_d);
        hsync_only();
        chk("R8 hd without vd", d_o, exp_d);
        vsync_hsync();
        exp_d = {6'h13, 6'h2C};
        chk("R8 committed", d_o, exp_d);

        // R9 freeze
        send(8'h30, 6'h01, 14, 2'b00);
        chk("R9 freeze set", {11'h0, frz_o}, 12'h1);
        send(8'h10, 6'h07, 14, 2'b00);
        send(8'h11, 6'h22, 14, 2'b00);
        send(8'h20, 6'h01, 14, 2'b00);
        send(8'h21, 6'h02, 14, 2'b00);
        vsync_hsync();
        all_out("R9 frozen");
        send(8'h30, 6'h00, 14, 2'b00);
        chk("R9 freeze cleared", {11'h0, frz_o}, 12'h0);
        all_out("R9 clearing frame commits nothing");
        send(8'h55, 6'h00, 14, 2'b00);
        exp_a = 6'h07; exp_c = 12'h081;
        all_out("R9 strobe kept data");
        vsync_hsync();
        exp_b = 6'h22;
        all_out("R9 video kept data");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule